// File: doc/BRIEF.md
# Two-Level Microprogrammed Control Sequencer

This block is the control unit of a small accumulator processor. It takes the opcode held in the datapath's instruction register, one ALU status flag and its own micro-step register, and from them produces the full control word that drives the datapath. The control store has two levels. A microcode store, addressed by status, opcode and micro-step, returns a narrow microword. That microword holds a 7-bit index into a nanomemory of wide control patterns, plus sequencing information for the next micro-step.

Register strobes are kept in the nanomemory as a 3-bit binary code and are decoded at the output into seven individual strobes. The program-counter address enable and the memory-address-register enable are never wanted together, so one nanoword bit drives the first and its complement drives the second. Whenever the datapath loads a new opcode, the microcode address moves straight into that opcode's microroutine without any explicit branch. The micro-step register is either a plain latch loaded from the microword's next-step field or, as a build option, a counter that advances by one or returns to zero.

Both stores are computed constants in the source. The built-in microprogram covers the shared fetch, add-immediate, unconditional jump and jump-if-status.

Top module: `useq_ctrl`

## Requirements
- R1: Reset is synchronous and active high. At the first clock edge with reset high, the micro-step returns to 0. Between edges, reset has no effect on the control word. With step 0 and opcode 0 the control word is 0x00080.
- R2: The microcode address is {status, opcode[5:0], step}. Opcode bits [7:6] have no effect, so opcode 0x41 behaves exactly like 0x01.
- R3: For every opcode, steps 0, 1 and 2 form the fetch and advance to steps 1, 2 and 3. Their control words are 0x00080, 0x02080 and 0x02288. The last of these is PC enable, ROM enable, IR strobe and PC increment.
- R4: After the fetch, step 3 is read under whatever opcode is present at that time (implicit microjump). If the opcode changes partway through a routine, the address follows the new opcode at the current step.
- R5: Opcode 1 (add immediate) produces 0x02082, 0x00504 and 0x08301 at steps 3, 4 and 5 (operand to MDR, ALU add to RESULT, RESULT to ACC with PC increment), then returns to step 0. The status bit has no effect on this routine.
- R6: Opcode 2 (jump) produces 0x02090 (ROM to PC) at step 3 and then returns to step 0.
- R7: Opcode 3 produces 0x02090 at step 3 when status is 1, and 0x00280 (PC increment only) when status is 0. Either way it then returns to step 0.
- R8: Control word bits [6:0] are the decoded strobes. Code k (1..7) drives bit k-1, in the order ACC, MDR, RESULT, IR, PC, MAR, OUT. Code 0 drives none, and at most one strobe is ever high.
- R9: Bit 7 (PC address enable) and bit 8 (MAR address enable) are always complements of each other.
- R10: Opcode 0 and every opcode with no routine (4..63) give one idle step 3 with control word 0x00100, then return to step 0.
- R11: The counter build option (COUNT_MODE=1) produces the same control word sequence as the default latch build for the built-in microprogram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| opcode_i | input | 8 | Opcode from the datapath instruction register |
| status_i | input | 1 | ALU status flag used for conditional routines |
| ctrl_o | output | 17 | Control word: [6:0] strobes, [7] PC enable, [8] MAR enable, [9] PC increment, [12:10] ALU function (1 = add), [13] ROM enable, [14] RAM enable, [15] RESULT enable, [16] input enable |

## Verification
The control word is combinational from the current micro-step, opcode and status. A change of opcode or status therefore shows on ctrl_o within the same cycle, while the step moves on exactly one clock edge later. The bench drives each vector just after a falling edge and compares the output a moment later, so every vector sees one rising edge between it and the previous one. Reset is checked both before and after its edge: the word is unchanged while reset is high and no edge has passed, and the fetch pattern appears after the edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W      = 8;
    localparam int OP_USED_W = 6;
    localparam int STEP_W    = 4;
    localparam int NIDX_W    = 7;
    localparam int SCODE_W   = 3;
    localparam int NSTRB     = (1 << SCODE_W) - 1;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_XOR  = 3'd5
    } alu_fn_e;

    typedef enum logic [SCODE_W-1:0] {
        STB_NONE = 3'd0,
        STB_ACC  = 3'd1,
        STB_MDR  = 3'd2,
        STB_RES  = 3'd3,
        STB_IR   = 3'd4,
        STB_PC   = 3'd5,
        STB_MAR  = 3'd6,
        STB_OUT  = 3'd7
    } strb_e;

    // wide pattern held in the nanomemory
    typedef struct packed {
        strb_e   strb;
        logic    pc_sel;
        logic    pc_inc;
        alu_fn_e alu;
        logic    rom_en;
        logic    ram_en;
        logic    result_en;
        logic    in_en;
    } nano_t;

    // narrow word held in the microcode store
    typedef struct packed {
        logic [NIDX_W-1:0] nidx;
        logic [STEP_W-1:0] next;
        logic              last;
    } uword_t;

    // control word as seen at the block output
    typedef struct packed {
        logic             in_en;
        logic             result_en;
        logic             ram_en;
        logic             rom_en;
        alu_fn_e          alu;
        logic             pc_inc;
        logic             mar_en;
        logic             pc_en;
        logic [NSTRB-1:0] strobe;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // nanomemory slots
    localparam int NI_IDLE = 0;
    localparam int NI_F0   = 1;
    localparam int NI_F1   = 2;
    localparam int NI_F2   = 3;
    localparam int NI_LDMD = 4;
    localparam int NI_ADD  = 5;
    localparam int NI_RACC = 6;
    localparam int NI_JMP  = 7;
    localparam int NI_SKIP = 8;

    // opcodes with routines
    localparam int OPC_NOP  = 0;
    localparam int OPC_ADDI = 1;
    localparam int OPC_JMP  = 2;
    localparam int OPC_JZ   = 3;

    localparam int FETCH_LEN = 3;

    function automatic nano_t nano_entry(input int idx);
        nano_t n;
        n = '0;
        case (idx)
            NI_F0: begin
                n.pc_sel = 1'b1;
            end
            NI_F1: begin
                n.pc_sel = 1'b1;
                n.rom_en = 1'b1;
            end
            NI_F2: begin
                n.pc_sel = 1'b1;
                n.rom_en = 1'b1;
                n.pc_inc = 1'b1;
                n.strb   = STB_IR;
            end
            NI_LDMD: begin
                n.pc_sel = 1'b1;
                n.rom_en = 1'b1;
                n.strb   = STB_MDR;
            end
            NI_ADD: begin
                n.alu  = ALU_ADD;
                n.strb = STB_RES;
            end
            NI_RACC: begin
                n.result_en = 1'b1;
                n.pc_inc    = 1'b1;
                n.strb      = STB_ACC;
            end
            NI_JMP: begin
                n.pc_sel = 1'b1;
                n.rom_en = 1'b1;
                n.strb   = STB_PC;
            end
            NI_SKIP: begin
                n.pc_sel = 1'b1;
                n.pc_inc = 1'b1;
            end
            default: n = '0;
        endcase
        return n;
    endfunction

    function automatic uword_t mk_uword(input int idx, input int nxt, input bit fin);
        uword_t u;
        u.nidx = NIDX_W'(idx);
        u.next = STEP_W'(nxt);
        u.last = fin;
        return u;
    endfunction

    function automatic uword_t ucode_entry(input int st, input int op, input int step);
        uword_t u;
        u = mk_uword(NI_IDLE, 0, 1'b1);
        if (step < FETCH_LEN) begin
            u = mk_uword(NI_F0 + step, step + 1, 1'b0);
        end else if (step == FETCH_LEN) begin
            case (op)
                OPC_ADDI: u = mk_uword(NI_LDMD, FETCH_LEN + 1, 1'b0);
                OPC_JMP:  u = mk_uword(NI_JMP, 0, 1'b1);
                OPC_JZ:   u = mk_uword((st != 0) ? NI_JMP : NI_SKIP, 0, 1'b1);
                default:  u = mk_uword(NI_IDLE, 0, 1'b1);
            endcase
        end else if (op == OPC_ADDI && step == FETCH_LEN + 1) begin
            u = mk_uword(NI_ADD, FETCH_LEN + 2, 1'b0);
        end else if (op == OPC_ADDI && step == FETCH_LEN + 2) begin
            u = mk_uword(NI_RACC, 0, 1'b1);
        end
        return u;
    endfunction

endpackage

// File: rtl/useq_step.sv
module useq_step #(
    parameter int STEP_BITS  = 4,
    parameter bit COUNT_MODE = 1'b0
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [STEP_BITS-1:0] next_i,
    input  logic                 last_i,
    output logic [STEP_BITS-1:0] step_o
);

    logic [STEP_BITS-1:0] step_d;

    generate
        if (COUNT_MODE) begin : g_count
            logic unused_next;
            assign unused_next = ^next_i;
            always_comb begin
                if (last_i) step_d = '0;
                else        step_d = step_o + STEP_BITS'(1);
            end
        end else begin : g_latch
            logic unused_last;
            assign unused_last = last_i;
            assign step_d = next_i;
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) step_o <= '0;
        else       step_o <= step_d;
    end

endmodule

// File: rtl/useq_urom.sv
module useq_urom
    import useq_pkg::*;
#(
    parameter int OP_USED   = OP_USED_W,
    parameter int STEP_BITS = STEP_W
) (
    input  logic [OP_USED+STEP_BITS:0] addr_i,
    output uword_t                     word_o
);

    localparam int ADDR_W = OP_USED + STEP_BITS + 1;
    localparam int DEPTH  = 1 << ADDR_W;

    uword_t rom [DEPTH];

    generate
        for (genvar a = 0; a < DEPTH; a++) begin : g_word
            localparam int ST  = (a >> (OP_USED + STEP_BITS)) & 1;
            localparam int OPV = (a >> STEP_BITS) & ((1 << OP_USED) - 1);
            localparam int STP = a & ((1 << STEP_BITS) - 1);
            assign rom[a] = ucode_entry(ST, OPV, STP);
        end
    endgenerate

    assign word_o = rom[addr_i];

endmodule

// File: rtl/useq_nrom.sv
module useq_nrom
    import useq_pkg::*;
#(
    parameter int IDX_BITS = NIDX_W
) (
    input  logic [IDX_BITS-1:0] idx_i,
    output nano_t               pat_o
);

    localparam int DEPTH = 1 << IDX_BITS;

    nano_t rom [DEPTH];

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_pat
            assign rom[k] = nano_entry(k);
        end
    endgenerate

    assign pat_o = rom[idx_i];

endmodule

// File: rtl/useq_sdec.sv
module useq_sdec #(
    parameter int CODE_BITS = 3
) (
    input  logic [CODE_BITS-1:0]        code_i,
    output logic [(1<<CODE_BITS)-2:0]   strb_o
);

    localparam int NOUT = (1 << CODE_BITS) - 1;

    generate
        for (genvar k = 1; k <= NOUT; k++) begin : g_line
            assign strb_o[k-1] = (code_i == CODE_BITS'(k));
        end
    endgenerate

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OP_BITS    = OP_W,
    parameter int OP_USED    = OP_USED_W,
    parameter int STEP_BITS  = STEP_W,
    parameter int NANO_BITS  = NIDX_W,
    parameter int SCODE_BITS = SCODE_W,
    parameter bit COUNT_MODE = 1'b0
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [OP_BITS-1:0] opcode_i,
    input  logic               status_i,
    output logic [CTRL_W-1:0]  ctrl_o
);

    localparam int UADDR_BITS = 1 + OP_USED + STEP_BITS;
    localparam int NSTROBES   = (1 << SCODE_BITS) - 1;

    logic [STEP_BITS-1:0]  step_q;
    logic [UADDR_BITS-1:0] uaddr;
    uword_t                uword;
    nano_t                 npat;
    logic [NSTROBES-1:0]   strobes;
    ctrl_t                 cw;

    generate
        if (OP_BITS > OP_USED) begin : g_drop_hi
            logic unused_op_hi;
            assign unused_op_hi = ^opcode_i[OP_BITS-1:OP_USED];
        end
    endgenerate

    assign uaddr = {status_i, opcode_i[OP_USED-1:0], step_q};

    useq_step #(
        .STEP_BITS  (STEP_BITS),
        .COUNT_MODE (COUNT_MODE)
    ) i_step (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .next_i (uword.next),
        .last_i (uword.last),
        .step_o (step_q)
    );

    useq_urom #(
        .OP_USED   (OP_USED),
        .STEP_BITS (STEP_BITS)
    ) i_urom (
        .addr_i (uaddr),
        .word_o (uword)
    );

    useq_nrom #(
        .IDX_BITS (NANO_BITS)
    ) i_nrom (
        .idx_i (uword.nidx),
        .pat_o (npat)
    );

    useq_sdec #(
        .CODE_BITS (SCODE_BITS)
    ) i_sdec (
        .code_i (npat.strb),
        .strb_o (strobes)
    );

    always_comb begin
        cw           = '0;
        cw.strobe    = strobes;
        cw.pc_en     = npat.pc_sel;
        cw.mar_en    = ~npat.pc_sel;
        cw.pc_inc    = npat.pc_inc;
        cw.alu       = npat.alu;
        cw.rom_en    = npat.rom_en;
        cw.ram_en    = npat.ram_en;
        cw.result_en = npat.result_en;
        cw.in_en     = npat.in_en;
    end

    assign ctrl_o = cw;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
#(
    parameter int STEP_BITS = STEP_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CTRL_W-1:0]    ctrl,
    input logic [STEP_BITS-1:0] step
);

    localparam int ACC_BIT = int'(STB_ACC) - 1;
    localparam int RES_BIT = int'(STB_RES) - 1;
    localparam int IR_BIT  = int'(STB_IR) - 1;
    localparam int FIRST_EXEC = FETCH_LEN;

    ctrl_t c;
    assign c = ctrl;

    // R1: the edge that ends reset leaves the sequencer at step 0
    assert_reset_step_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> step == '0);

    // R3: step 0 always moves on to step 1
    assert_fetch_order_R3: assert property (@(posedge clk) disable iff (rst)
        step == '0 |=> step == STEP_BITS'(1));

    // R3: the IR strobe only follows a cycle that read the ROM at the PC
    assert_ir_after_read_R3: assert property (@(posedge clk) disable iff (rst)
        c.strobe[IR_BIT] |-> $past(c.rom_en && c.pc_en));

    // R4: loading the IR lands on the first execute step
    assert_microjump_R4: assert property (@(posedge clk) disable iff (rst)
        c.strobe[IR_BIT] |=> step == STEP_BITS'(FIRST_EXEC));

    // R5: the accumulator is only written right after RESULT was strobed
    assert_acc_after_result_R5: assert property (@(posedge clk) disable iff (rst)
        c.strobe[ACC_BIT] |-> $past(c.strobe[RES_BIT]));

endmodule

bind useq_ctrl useq_chk #(
    .STEP_BITS (STEP_BITS)
) i_useq_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .ctrl (ctrl_o),
    .step (step_q)
);

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 38;

    // entry: {opcode, status, expected control word, requirement number}
    localparam logic [29:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 17'h00080, 4'd3},   // R3 fetch step 0
        {8'h00, 1'b0, 17'h02080, 4'd3},   // R3 fetch step 1
        {8'h00, 1'b0, 17'h02288, 4'd3},   // R3 fetch step 2, IR load
        {8'h01, 1'b0, 17'h02082, 4'd4},   // R4 jump into add routine
        {8'h01, 1'b1, 17'h00504, 4'd5},   // R5 add, status ignored
        {8'h01, 1'b0, 17'h08301, 4'd5},   // R5 result to acc
        {8'h01, 1'b0, 17'h00080, 4'd5},   // R5 back to fetch
        {8'h01, 1'b0, 17'h02080, 4'd3},
        {8'h01, 1'b0, 17'h02288, 4'd3},
        {8'h02, 1'b0, 17'h02090, 4'd6},   // R6 jump
        {8'h02, 1'b0, 17'h00080, 4'd6},   // R6 back to fetch
        {8'h02, 1'b0, 17'h02080, 4'd3},
        {8'h02, 1'b0, 17'h02288, 4'd3},
        {8'h03, 1'b1, 17'h02090, 4'd7},   // R7 taken
        {8'h03, 1'b0, 17'h00080, 4'd7},
        {8'h03, 1'b0, 17'h02080, 4'd3},
        {8'h03, 1'b0, 17'h02288, 4'd3},
        {8'h03, 1'b0, 17'h00280, 4'd7},   // R7 not taken, skip operand
        {8'h41, 1'b0, 17'h00080, 4'd7},
        {8'h41, 1'b0, 17'h02080, 4'd3},
        {8'h41, 1'b0, 17'h02288, 4'd3},
        {8'h41, 1'b0, 17'h02082, 4'd2},   // R2 high opcode bits dropped
        {8'h41, 1'b0, 17'h00504, 4'd2},
        {8'h41, 1'b0, 17'h08301, 4'd2},
        {8'hC1, 1'b0, 17'h00080, 4'd2},
        {8'hC1, 1'b0, 17'h02080, 4'd3},
        {8'hC1, 1'b0, 17'h02288, 4'd3},
        {8'h05, 1'b0, 17'h00100, 4'd10},  // R10 opcode without a routine
        {8'h05, 1'b0, 17'h00080, 4'd10},
        {8'h05, 1'b0, 17'h02080, 4'd3},
        {8'h05, 1'b0, 17'h02288, 4'd3},
        {8'h00, 1'b1, 17'h00100, 4'd10},  // R10 opcode 0 idles once
        {8'h00, 1'b0, 17'h00080, 4'd10},
        {8'h00, 1'b0, 17'h02080, 4'd3},
        {8'h00, 1'b0, 17'h02288, 4'd3},
        {8'h01, 1'b0, 17'h02082, 4'd5},
        {8'h02, 1'b0, 17'h00100, 4'd4},   // R4 opcode switched mid routine
        {8'h02, 1'b0, 17'h00080, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = '0;
    logic        status = 1'b0;
    logic [16:0] ctrl_lat;
    logic [16:0] ctrl_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk_i    (clk),
        .rst_i    (rst),
        .opcode_i (opcode),
        .status_i (status),
        .ctrl_o   (ctrl_lat)
    );

    useq_ctrl #(.COUNT_MODE(1'b1)) i_useq_ctrl_cnt (
        .clk_i    (clk),
        .rst_i    (rst),
        .opcode_i (opcode),
        .status_i (status),
        .ctrl_o   (ctrl_cnt)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [16:0] exp);
        check(req, ctrl_lat, exp);
        check({"R11 ", req}, ctrl_cnt, exp);
        // R8: no more than one strobe line high
        check("R8", 17'($countones(ctrl_lat[6:0]) <= 1), 17'd1);
        // R9: PC and MAR enables complementary
        check("R9", 17'(ctrl_lat[7] ^ ctrl_lat[8]), 17'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_word("R1", 17'h00080);   // R1 reset state: fetch step 0
        // table walk: each vector one clock after the previous
        for (int i = 0; i < NVEC; i++) begin
            if (i != 0) @(negedge clk);
            opcode = VEC[i][29:22];
            status = VEC[i][21];
            #1;
            check_word($sformatf("R%0d vec %0d", VEC[i][3:0], i), VEC[i][20:4]);
        end
        // directed: reset in the middle of the add routine
        @(negedge clk);
        opcode = 8'h01;
        status = 1'b0;
        #1;
        check_word("R3", 17'h02080);
        @(negedge clk); #1;
        check_word("R3", 17'h02288);
        @(negedge clk); #1;
        check_word("R5", 17'h02082);
        @(negedge clk); #1;
        check_word("R5", 17'h00504);
        rst = 1'b1;
        #1;
        check_word("R1 before edge", 17'h00504);   // R1 synchronous
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_word("R1 after edge", 17'h00080);    // R1 back at step 0
        @(negedge clk); #1;
        check_word("R1 restart", 17'h02080);
        finish_run();
    end

endmodule